// File: doc/BRIEF.md
# CPU Bus System Controller

This controller is the glue logic between a 16-bit-address CPU and its memories and peripherals, for a CPU that puts its upper address byte (the bank) on the data bus while the phase-2 clock is low. It runs from a fast system clock and samples phase 2 as an ordinary input. At the first system-clock edge that sees phase 2 high after it was low, it captures the data bus as the bank byte. The low bits of that byte drive the high address lines.

While phase 2 is high and the CPU flags a valid address, the full 24-bit address (bank plus low 16 bits) is decoded into one of three active-low selects: RAM, ROM or I/O. Read and write strobes are also qualified by phase 2 being high. Several active-low peripheral interrupt requests are merged through a fixed mask parameter into one active-low CPU interrupt line.

Top module: `sysctl_bus_ctrl`

## Requirements
- R1: At the first clock edge where `phi2_i` is sampled 1 and was sampled 0 at the edge before, `data_i` is stored as the bank byte. The stored value is held unchanged at every other edge.
- R2: `addr_hi_o` equals the low 3 bits of the stored bank byte and changes only at a capture edge or at reset.
- R3: `io_cs_n_o` is 0 when the stored bank is 0x00 and `addr_i` is in 0xDF00..0xDFFF, provided the select qualification of R6 holds.
- R4: `rom_cs_n_o` is 0 when the stored bank is 0x00 and `addr_i` is in 0xE000..0xFFFF, provided R6 holds.
- R5: `ram_cs_n_o` is 0 for every other address, including any address whose stored bank is nonzero, provided R6 holds.
- R6: All three selects are 1 unless `phi2_i` is 1 now, `phi2_i` was 1 at the previous clock edge, and `vda_i` or `vpa_i` is 1.
- R7: At most one of the three selects is 0 at any time.
- R8: `rd_n_o` is 0 exactly when the phase-high qualification of R6 holds (ignoring `vda_i` and `vpa_i`) and `rwb_i` is 1. `wr_n_o` is 0 under the same phase qualification when `rwb_i` is 0.
- R9: `irq_n_o` is 0 when any `irq_n_i` bit whose bit in `IRQ_MASK` is 1 is 0. Inputs whose mask bit is 0 have no effect. With the default mask 4'b1011, bit 2 is ignored.
- R10: While `rst_i` is 1 at a clock edge, the bank byte and the stored phase are cleared. After that edge, `addr_hi_o` is 0 and all selects and strobes are 1, even if `phi2_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than phase 2 |
| rst_i | input | 1 | Synchronous active-high reset |
| phi2_i | input | 1 | CPU phase-2 clock, sampled |
| addr_i | input | 16 | Low 16 CPU address bits |
| data_i | input | 8 | CPU data bus (carries the bank while phase 2 is low) |
| rwb_i | input | 1 | 1 = read, 0 = write |
| vda_i | input | 1 | Valid data address |
| vpa_i | input | 1 | Valid program address |
| irq_n_i | input | N_IRQ | Active-low peripheral interrupt requests |
| addr_hi_o | output | 3 | High address lines A16..A18 |
| ram_cs_n_o | output | 1 | Active-low RAM select |
| rom_cs_n_o | output | 1 | Active-low ROM select |
| io_cs_n_o | output | 1 | Active-low I/O select |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| irq_n_o | output | 1 | Active-low merged CPU interrupt |

## Verification
The bank byte and the high address lines update one clock edge after phase 2 first reads high. The selects and strobes become due in that same cycle, because they wait for the registered phase. They fall back combinationally, in the same cycle phase 2 drops. The interrupt output follows its inputs with no delay. The bench drives inputs just after each rising edge, advances its behavioural model at the rising edge, and compares every output at the following falling edge. Each result is therefore checked in the cycle it is due. The data bus is changed during phase-high to confirm the held bank.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_RAM  = 2'd1,
        REG_ROM  = 2'd2,
        REG_IO   = 2'd3
    } region_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
    } sel_n_t;

    localparam sel_n_t SEL_IDLE = '{ram: 1'b1, rom: 1'b1, io: 1'b1};

    function automatic logic in_window(input logic [15:0] a,
                                       input logic [15:0] lo,
                                       input logic [15:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic region_e map_region(input logic        bank_zero,
                                           input logic [15:0] a,
                                           input logic [15:0] io_lo,
                                           input logic [15:0] io_hi,
                                           input logic [15:0] rom_lo,
                                           input logic [15:0] rom_hi);
        if (bank_zero && in_window(a, io_lo, io_hi))
            return REG_IO;
        if (bank_zero && in_window(a, rom_lo, rom_hi))
            return REG_ROM;
        return REG_RAM;
    endfunction

endpackage

// File: rtl/sysctl_bank_latch.sv
module sysctl_bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              phi2_i,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              phase_hi_o
);
    logic phi2_q;
    logic rise;

    assign rise = phi2_i & ~phi2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phi2_q <= 1'b0;
            bank_o <= '0;
        end else begin
            phi2_q <= phi2_i;
            if (rise)
                bank_o <= data_i;
        end
    end

    // high only once the bank for this cycle is in place
    assign phase_hi_o = phi2_i & phi2_q;
endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int          BANK_W   = 8,
    parameter logic [15:0] IO_LO    = 16'hDF00,
    parameter logic [15:0] IO_HI    = 16'hDFFF,
    parameter logic [15:0] ROM_LO   = 16'hE000,
    parameter logic [15:0] ROM_HI   = 16'hFFFF
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [15:0]       addr_i,
    input  logic              phase_hi_i,
    input  logic              valid_i,
    input  logic              rwb_i,
    output sel_n_t            sel_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o
);
    region_e region;

    always_comb begin
        region = REG_NONE;
        if (phase_hi_i && valid_i)
            region = map_region(bank_i == '0, addr_i, IO_LO, IO_HI, ROM_LO, ROM_HI);
    end

    always_comb begin
        sel_n_o = SEL_IDLE;
        unique case (region)
            REG_RAM:  sel_n_o.ram = 1'b0;
            REG_ROM:  sel_n_o.rom = 1'b0;
            REG_IO:   sel_n_o.io  = 1'b0;
            default:  sel_n_o     = SEL_IDLE;
        endcase
    end

    assign rd_n_o = ~(phase_hi_i & rwb_i);
    assign wr_n_o = ~(phase_hi_i & ~rwb_i);
endmodule

// File: rtl/sysctl_irq_merge.sv
module sysctl_irq_merge #(
    parameter int             N_IRQ = 4,
    parameter logic [N_IRQ-1:0] MASK = '1
) (
    input  logic [N_IRQ-1:0] irq_n_i,
    output logic             irq_n_o
);
    logic [N_IRQ-1:0] req;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        if (MASK[g]) begin : g_on
            assign req[g] = ~irq_n_i[g];
        end else begin : g_off
            assign req[g] = 1'b0;
        end
    end

    assign irq_n_o = ~(|req);
endmodule

// File: rtl/sysctl_bus_ctrl.sv
module sysctl_bus_ctrl
    import sysctl_pkg::*;
#(
    parameter int               BANK_W   = 8,
    parameter int               HI_W     = 3,
    parameter int               N_IRQ    = 4,
    parameter logic [N_IRQ-1:0] IRQ_MASK = 4'b1011,
    parameter logic [15:0]      IO_LO    = 16'hDF00,
    parameter logic [15:0]      IO_HI    = 16'hDFFF,
    parameter logic [15:0]      ROM_LO   = 16'hE000,
    parameter logic [15:0]      ROM_HI   = 16'hFFFF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              phi2_i,
    input  logic [15:0]       addr_i,
    input  logic [BANK_W-1:0] data_i,
    input  logic              rwb_i,
    input  logic              vda_i,
    input  logic              vpa_i,
    input  logic [N_IRQ-1:0]  irq_n_i,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic              ram_cs_n_o,
    output logic              rom_cs_n_o,
    output logic              io_cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              irq_n_o
);
    logic [BANK_W-1:0] bank;
    logic              phase_hi;
    sel_n_t            sel_n;

    sysctl_bank_latch #(.BANK_W(BANK_W)) u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .phi2_i     (phi2_i),
        .data_i     (data_i),
        .bank_o     (bank),
        .phase_hi_o (phase_hi)
    );

    sysctl_decode #(
        .BANK_W (BANK_W),
        .IO_LO  (IO_LO),
        .IO_HI  (IO_HI),
        .ROM_LO (ROM_LO),
        .ROM_HI (ROM_HI)
    ) u_dec (
        .bank_i     (bank),
        .addr_i     (addr_i),
        .phase_hi_i (phase_hi),
        .valid_i    (vda_i | vpa_i),
        .rwb_i      (rwb_i),
        .sel_n_o    (sel_n),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o)
    );

    sysctl_irq_merge #(.N_IRQ(N_IRQ), .MASK(IRQ_MASK)) u_irq (
        .irq_n_i (irq_n_i),
        .irq_n_o (irq_n_o)
    );

    assign addr_hi_o  = bank[HI_W-1:0];
    assign ram_cs_n_o = sel_n.ram;
    assign rom_cs_n_o = sel_n.rom;
    assign io_cs_n_o  = sel_n.io;
endmodule

// File: rtl/sysctl_bus_ctrl_chk.sv
module sysctl_bus_ctrl_chk #(
    parameter int HI_W   = 3,
    parameter int BANK_W = 8,
    parameter int N_IRQ  = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              phi2_i,
    input logic [BANK_W-1:0] data_i,
    input logic              vda_i,
    input logic              vpa_i,
    input logic [N_IRQ-1:0]  irq_n_i,
    input logic [HI_W-1:0]   addr_hi_o,
    input logic              ram_cs_n_o,
    input logic              rom_cs_n_o,
    input logic              io_cs_n_o,
    input logic              rd_n_o,
    input logic              wr_n_o,
    input logic              irq_n_o
);
    AST_BANK_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phi2_i && !$past(phi2_i) && !$past(rst_i)) |=> (addr_hi_o == $past(data_i[HI_W-1:0]))); // R1

    AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(phi2_i) && $past(phi2_i, 2)) |-> $stable(addr_hi_o)); // R2

    AST_SEL_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!phi2_i || !(vda_i || vpa_i)) |-> (ram_cs_n_o && rom_cs_n_o && io_cs_n_o)); // R6

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({~ram_cs_n_o, ~rom_cs_n_o, ~io_cs_n_o}) <= 1); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(!rd_n_o && !wr_n_o)); // R8

    AST_STROBE_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        !phi2_i |-> (rd_n_o && wr_n_o)); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (&irq_n_i) |-> irq_n_o); // R9

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        $past(rst_i) && rst_i |-> (addr_hi_o == '0 && ram_cs_n_o && rom_cs_n_o && io_cs_n_o)); // R10
endmodule

bind sysctl_bus_ctrl sysctl_bus_ctrl_chk #(
    .HI_W(HI_W), .BANK_W(BANK_W), .N_IRQ(N_IRQ)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .phi2_i     (phi2_i),
    .data_i     (data_i),
    .vda_i      (vda_i),
    .vpa_i      (vpa_i),
    .irq_n_i    (irq_n_i),
    .addr_hi_o  (addr_hi_o),
    .ram_cs_n_o (ram_cs_n_o),
    .rom_cs_n_o (rom_cs_n_o),
    .io_cs_n_o  (io_cs_n_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/sysctl_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sysctl_bus_ctrl_tb;
    localparam logic [3:0] MASK = 4'b1011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic        rwb = 1'b1;
    logic        vda = 1'b1;
    logic        vpa = 1'b0;
    logic [3:0]  irq_n = 4'hF;
    logic [2:0]  addr_hi;
    logic        ram_cs_n, rom_cs_n, io_cs_n, rd_n, wr_n, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    // behavioural model state
    int bank_m = 0;
    bit prev_m = 0;

    always #2.5 clk = ~clk;

    sysctl_bus_ctrl u_dut (
        .clk_i(clk), .rst_i(rst), .phi2_i(phi2), .addr_i(addr), .data_i(data),
        .rwb_i(rwb), .vda_i(vda), .vpa_i(vpa), .irq_n_i(irq_n),
        .addr_hi_o(addr_hi), .ram_cs_n_o(ram_cs_n), .rom_cs_n_o(rom_cs_n),
        .io_cs_n_o(io_cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .irq_n_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            bank_m = 0;
            prev_m = 0;
        end else begin
            if (phi2 && !prev_m) bank_m = data;   // R1 capture
            prev_m = phi2;
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            bit phase, sel, any;
            int e_ram, e_rom, e_io;
            phase = phi2 && prev_m;
            sel   = phase && (vda || vpa);
            e_ram = 1; e_rom = 1; e_io = 1;
            if (sel) begin
                if (bank_m == 0 && addr >= 16'hDF00 && addr <= 16'hDFFF) e_io = 0;
                else if (bank_m == 0 && addr >= 16'hE000) e_rom = 0;
                else e_ram = 0;
            end
            any = 0;
            for (int i = 0; i < 4; i++)
                if (MASK[i] && !irq_n[i]) any = 1;
            chk(rst ? "R10 addr_hi" : "R2 addr_hi", addr_hi, bank_m & 7);
            chk(rst ? "R10 ram" : "R5 ram_cs", ram_cs_n, e_ram);
            chk(rst ? "R10 rom" : "R4 rom_cs", rom_cs_n, e_rom);
            chk(rst ? "R10 io" : "R3 io_cs", io_cs_n, e_io);
            chk("R8 rd", rd_n, !(phase && rwb));
            chk("R8 wr", wr_n, !(phase && !rwb));
            chk("R9 irq", irq_o, !any);
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    // one full bus cycle: bank on data while phase 2 low, then other data while high
    task automatic bus(input logic [7:0] b, input logic [15:0] a,
                       input logic r, input logic d, input logic p);
        phi2 = 1'b0; data = b; addr = a; rwb = r; vda = d; vpa = p;
        step(2);
        phi2 = 1'b1;
        step(1);
        data = 8'hA5;   // R1: later data must not disturb the bank
        step(3);
    endtask

    initial begin
        step(3);                      // R10 with phase 2 high during reset
        rst = 1'b0;
        bus(8'h00, 16'hDF00, 1, 1, 0);  // R3 low edge
        bus(8'h00, 16'hDFFF, 0, 1, 0);  // R3 high edge, write
        bus(8'h00, 16'hDEFF, 1, 0, 1);  // R5 just below io
        bus(8'h00, 16'hE000, 1, 0, 1);  // R4 low edge
        bus(8'h00, 16'hFFFF, 1, 1, 1);  // R4 high edge
        bus(8'h01, 16'hFFFF, 1, 1, 0);  // R5 nonzero bank
        bus(8'h80, 16'hDF10, 0, 1, 0);  // R5 bank with addr_hi 0
        bus(8'h07, 16'h1234, 1, 0, 0);  // R6 no valid address
        bus(8'hFE, 16'h0000, 0, 0, 1);  // R2 addr_hi 6
        for (int m = 0; m < 16; m++) begin  // R9 all request patterns
            irq_n = m[3:0];
            step(2);
        end
        irq_n = 4'hF;
        bus(8'h00, 16'hE123, 1, 1, 0);
        rst = 1'b1;                    // R10 mid-run reset
        step(2);
        rst = 1'b0;
        phi2 = 1'b0;
        step(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule